// File: doc/BRIEF.md
# Priority Transport Packet Scheduler

This block decides, once per scheduling slot, which 188-byte transport packet goes out to the network side. It runs in one clock domain. Elementary-stream program sources raise a level "packet waiting" request. Four timed packet kinds are due when their own repetition timers expire: the association table, the map table, the selection-information table and the clock-reference packet. A null filler packet may be sent when nothing else is waiting, but only up to a fixed maximum rate. On many slots nothing is sent at all.

The scheduler sends the chosen packet as a byte stream. It builds the four header bytes itself: sync byte, PID and flags. The payload bytes come from the granted source through a pass-through byte input, and the grant vector tells that source to present them. For null packets the scheduler supplies every payload byte. A one-cycle trigger marks the start of a packet, and a busy flag covers the whole transfer. The 13-bit PID is held on its own output for the whole transfer, so that continuity counting can be done downstream for each PID.

The output side is valid/ready. `out_valid` stays high for every byte of a packet until that byte is accepted. A low `out_ready` stalls the packet at its current byte with nothing lost, and back-pressure only lengthens the busy period. The slot timer keeps running during a stall. Any slot boundary that falls while the block is busy passes without a selection. The program and timed requests that were pending stay pending.

Top module: `tsp_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, `pkt_busy`, `out_valid`, `pkt_trig` and `src_grant` are all zero.
- R2: If any program request is high at a selection, a program packet is chosen ahead of every timed and null packet. Among programs the lowest index wins, and program i carries PID `PROG_PID_BASE + i`.
- R3: When no program is waiting, due timed packets are served one per slot in the order association table (PID 0x0000), then map table (`PMT_PID`), then selection table (`SIT_PID`), then clock reference (`PCR_PID`).
- R4: Each timed kind becomes due once every `*_PERIOD` cycles counted from reset. A due kind stays pending until it is sent, and several expiries before it is sent merge into one packet.
- R5: A null packet has PID 0x1FFF, and all 184 of its payload bytes are 0xFF. It is chosen only when no program request and no timed kind is pending.
- R6: Two null packets never start fewer than `NULL_GAP` slots apart. A slot with nothing eligible sends no packet.
- R7: Byte 0 of every packet is 0x47. Byte 1 is {3'b000, PID[12:8]}, byte 2 is PID[7:0] and byte 3 is 0x10. In a non-null packet, bytes 4 to 187 are copied from `pay_data`, and `pay_take` is high on exactly those accepted beats.
- R8: `pkt_trig` is high for one cycle, together with the first byte. `pkt_busy` equals `out_valid` for the whole packet, and `out_last` is high on byte 187. Busy falls in the cycle after that byte is accepted. `pkt_pid` and `src_grant` stay stable while busy.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and the byte position hold their values.
- R10: No selection is made while busy. A request raised or still pending during a transfer is served at a later slot.
- R11: A packet starts only in the cycle after a slot boundary, which comes every `SLOT_CYC` cycles from reset. Any two packet starts are therefore a multiple of `SLOT_CYC` apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_rdy | input | NUM_PROG | Level request: a program has a complete packet waiting |
| out_data | output | 8 | Packet byte |
| out_valid | output | 1 | Byte on `out_data` is valid |
| out_ready | input | 1 | Sink accepts the byte this cycle |
| out_last | output | 1 | Current byte is byte 187 |
| pkt_trig | output | 1 | One-cycle strobe at packet start |
| pkt_busy | output | 1 | Packet transfer in progress |
| pkt_pid | output | 13 | PID of the packet in transfer |
| src_grant | output | NUM_PROG+5 | One-hot granted source (programs, four timed kinds, null) |
| pay_data | input | 8 | Payload byte from the granted source |
| pay_take | output | 1 | A payload byte was consumed this cycle |

## Verification
The idle pattern has no program requests and an always-ready sink. It shows whether timers repeat on schedule, whether the four timed kinds come out in priority order when all of them fall due together, and whether null filler keeps its minimum spacing. The program pattern holds two requests across several table expiries, then only the higher index, then none. This separates strict program precedence and index order from the draining of merged pending tables afterwards. A periodic back-pressure pattern shows that stalled bytes hold their value and that packet starts still land on slot boundaries when transfers outlast a slot.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  localparam int PKT_BYTES = 188;
  localparam int HDR_BYTES = 4;
  localparam int N_TIMED   = 4;
  localparam int IDX_W     = 8;

  localparam logic [7:0]  SYNC_BYTE  = 8'h47;
  localparam logic [7:0]  FLAGS_BYTE = 8'h10;
  localparam logic [7:0]  FILL_BYTE  = 8'hFF;
  localparam logic [12:0] PID_PAT    = 13'h0000;
  localparam logic [12:0] PID_NULL   = 13'h1FFF;
endpackage

// File: rtl/tsp_rep_timer.sv
module tsp_rep_timer #(
  parameter int unsigned PERIOD = 1000,
  parameter int          CW     = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic due
);
  logic [CW-1:0] cnt;
  logic          fire;

  assign fire = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      due <= 1'b0;
    end else begin
      cnt <= fire ? '0 : cnt + 1'b1;
      if (fire)     due <= 1'b1;
      else if (clr) due <= 1'b0;
    end
  end

  // R4: pending stays until served
  p_due_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    due && !clr |=> due);
endmodule

// File: rtl/tsp_arbiter.sv
module tsp_arbiter #(
  parameter int          NP            = 2,
  parameter logic [12:0] PROG_PID_BASE = 13'h0100,
  parameter logic [12:0] PMT_PID       = 13'h0020,
  parameter logic [12:0] SIT_PID       = 13'h001F,
  parameter logic [12:0] PCR_PID       = 13'h0030,
  localparam int         NS            = NP + 5
) (
  input  logic [NS-1:0] req,
  output logic [NS-1:0] pick,
  output logic [12:0]   pick_pid
);
  import tsp_pkg::*;

  function automatic logic [12:0] pid_of(input int i);
    if (i < NP)           return PROG_PID_BASE + 13'(i);
    else if (i == NP)     return PID_PAT;
    else if (i == NP + 1) return PMT_PID;
    else if (i == NP + 2) return SIT_PID;
    else if (i == NP + 3) return PCR_PID;
    else                  return PID_NULL;
  endfunction

  // lowest set bit wins: programs, then timed kinds in order, then null
  assign pick = req & (~req + 1'b1);

  always_comb begin
    pick_pid = '0;
    for (int i = 0; i < NS; i++)
      if (pick[i]) pick_pid = pick_pid | pid_of(i);
  end
endmodule

// File: rtl/tsp_emitter.sv
module tsp_emitter #(
  parameter int NS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [12:0]   start_pid,
  input  logic          start_null,
  input  logic [NS-1:0] start_grant,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_valid,
  output logic          out_last,
  output logic          trig,
  output logic          busy,
  output logic [12:0]   pid,
  output logic [NS-1:0] grant,
  input  logic [7:0]    pay_data,
  output logic          pay_take
);
  import tsp_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);
  localparam logic [IDX_W-1:0] PAY_IDX  = IDX_W'(HDR_BYTES);

  logic [IDX_W-1:0] idx;
  logic             null_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      trig   <= 1'b0;
      idx    <= '0;
      pid    <= '0;
      null_q <= 1'b0;
      grant  <= '0;
    end else begin
      trig <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        trig   <= 1'b1;
        idx    <= '0;
        pid    <= start_pid;
        null_q <= start_null;
        grant  <= start_grant;
      end else if (busy && out_ready) begin
        if (idx == LAST_IDX) begin
          busy  <= 1'b0;
          grant <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assign out_valid = busy;
  assign out_last  = busy && (idx == LAST_IDX);
  assign pay_take  = busy && out_ready && !null_q && (idx >= PAY_IDX);

  always_comb begin
    case (idx)
      IDX_W'(0): out_data = SYNC_BYTE;
      IDX_W'(1): out_data = {3'b000, pid[12:8]};
      IDX_W'(2): out_data = pid[7:0];
      IDX_W'(3): out_data = FLAGS_BYTE;
      default:   out_data = null_q ? FILL_BYTE : pay_data;
    endcase
  end

  p_last_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last && out_ready |=> !busy);
  p_grant_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !trig |-> $stable(grant) && $stable(pid));
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !out_ready |=> busy && $stable(idx));
endmodule

// File: rtl/tsp_sched.sv
module tsp_sched
  import tsp_pkg::*;
#(
  parameter int          NUM_PROG      = 2,
  parameter int          SLOT_CYC      = 1024,
  parameter int          NULL_GAP      = 4,
  parameter int          TMR_W         = 32,
  parameter int unsigned PAT_PERIOD    = 10_000_000,
  parameter int unsigned PMT_PERIOD    = 10_000_000,
  parameter int unsigned SIT_PERIOD    = 100_000_000,
  parameter int unsigned PCR_PERIOD    = 4_000_000,
  parameter logic [12:0] PROG_PID_BASE = 13'h0100,
  parameter logic [12:0] PMT_PID       = 13'h0020,
  parameter logic [12:0] SIT_PID       = 13'h001F,
  parameter logic [12:0] PCR_PID       = 13'h0030,
  localparam int         NS            = NUM_PROG + N_TIMED + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PROG-1:0] prog_rdy,
  output logic [7:0]          out_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_last,
  output logic                pkt_trig,
  output logic                pkt_busy,
  output logic [12:0]         pkt_pid,
  output logic [NS-1:0]       src_grant,
  input  logic [7:0]          pay_data,
  output logic                pay_take
);
  localparam int NULL_IX = NS - 1;
  localparam int SW      = $clog2(SLOT_CYC);
  localparam int GW      = $clog2(NULL_GAP + 1);

  logic [SW-1:0]      slot_cnt;
  logic               tick;
  logic [GW-1:0]      gap_cnt;
  logic               null_ok;
  logic [N_TIMED-1:0] due;
  logic [N_TIMED-1:0] clr;
  logic [NS-1:0]      req;
  logic [NS-1:0]      pick;
  logic [12:0]        pick_pid;
  logic               select;
  logic               start;

  assign tick    = (slot_cnt == SW'(SLOT_CYC - 1));
  assign null_ok = (gap_cnt >= GW'(NULL_GAP - 1));
  assign req     = {null_ok, due, prog_rdy};
  assign select  = tick && !pkt_busy;
  assign start   = select && (|pick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_cnt <= '0;
      gap_cnt  <= '0;
    end else begin
      slot_cnt <= tick ? '0 : slot_cnt + 1'b1;
      if (tick) begin
        if (select && pick[NULL_IX])          gap_cnt <= '0;
        else if (gap_cnt < GW'(NULL_GAP - 1)) gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < N_TIMED; k++) begin : g_tmr
    localparam int unsigned PER = (k == 0) ? PAT_PERIOD :
                                  (k == 1) ? PMT_PERIOD :
                                  (k == 2) ? SIT_PERIOD : PCR_PERIOD;
    assign clr[k] = select && pick[NUM_PROG + k];
    tsp_rep_timer #(.PERIOD(PER), .CW(TMR_W)) i_tmr (
      .clk(clk), .rst_n(rst_n), .clr(clr[k]), .due(due[k]));
  end

  tsp_arbiter #(
    .NP(NUM_PROG), .PROG_PID_BASE(PROG_PID_BASE),
    .PMT_PID(PMT_PID), .SIT_PID(SIT_PID), .PCR_PID(PCR_PID)
  ) i_arb (
    .req(req), .pick(pick), .pick_pid(pick_pid));

  tsp_emitter #(.NS(NS)) i_emit (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pid(pick_pid),
    .start_null(pick[NULL_IX]), .start_grant(pick), .out_ready(out_ready),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .trig(pkt_trig), .busy(pkt_busy), .pid(pkt_pid), .grant(src_grant),
    .pay_data(pay_data), .pay_take(pay_take));

  p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_busy |-> !start);
  p_prog_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && (|prog_rdy) |-> |pick[NUM_PROG-1:0]);
  p_pat_before_pmt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start && pick[NUM_PROG+1] |-> !due[0]);
  p_null_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start && pick[NULL_IX] |-> (prog_rdy == '0) && (due == '0));
  p_trig_on_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_trig |-> $past(tick));
endmodule

// File: tb/test_tsp_sched.sv
module test_tsp_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 2;
  localparam int SLOT = 256;
  localparam int GAP  = 2;
  localparam int PER  = 3000;
  localparam int NS   = NP + 5;
  localparam logic [12:0] P_BASE = 13'h0040;
  localparam logic [12:0] P_PAT  = 13'h0000;
  localparam logic [12:0] P_PMT  = 13'h0020;
  localparam logic [12:0] P_SIT  = 13'h001F;
  localparam logic [12:0] P_PCR  = 13'h0030;
  localparam logic [12:0] P_NULL = 13'h1FFF;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] prog_rdy;
  logic [7:0]    out_data;
  logic          out_valid;
  logic          out_ready;
  logic          out_last;
  logic          pkt_trig;
  logic          pkt_busy;
  logic [12:0]   pkt_pid;
  logic [NS-1:0] src_grant;
  logic [7:0]    pay_data;
  logic          pay_take;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  int log_pid [0:1023];
  int log_cyc [0:1023];
  int n_log = 0;
  int mon_idx = 0;
  int n_stall = 0;
  bit stall_pend = 0;
  bit last_pend = 0;
  logic [7:0] stall_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pay_data = 8'hC3 ^ pkt_pid[7:0];

  tsp_sched #(
    .NUM_PROG(NP), .SLOT_CYC(SLOT), .NULL_GAP(GAP), .TMR_W(16),
    .PAT_PERIOD(PER), .PMT_PERIOD(PER), .SIT_PERIOD(PER), .PCR_PERIOD(PER),
    .PROG_PID_BASE(P_BASE), .PMT_PID(P_PMT), .SIT_PID(P_SIT), .PCR_PID(P_PCR)
  ) i_tsp_sched (
    .clk(clk), .rst_n(rst_n), .prog_rdy(prog_rdy), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .pkt_trig(pkt_trig), .pkt_busy(pkt_busy), .pkt_pid(pkt_pid),
    .src_grant(src_grant), .pay_data(pay_data), .pay_take(pay_take));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // stream monitor: R5 R7 R8 R9
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_pend) begin
        chk(out_valid && out_data == stall_data, "R9", "stalled byte held",
            out_data, stall_data);
        stall_pend = 0;
      end
      if (last_pend) begin
        chk(!pkt_busy, "R8", "busy low after last byte", pkt_busy, 0);
        last_pend = 0;
      end
      if (pkt_trig) begin
        chk(pkt_busy && mon_idx == 0, "R8", "trig with first byte", mon_idx, 0);
        if (n_log < 1024) begin
          log_pid[n_log] = pkt_pid;
          log_cyc[n_log] = cyc;
          n_log++;
        end
      end
      if (out_valid && out_ready) begin
        logic [7:0] exp_b;
        string      rq;
        rq = "R7";
        case (mon_idx)
          0: exp_b = 8'h47;
          1: exp_b = {3'b000, pkt_pid[12:8]};
          2: exp_b = pkt_pid[7:0];
          3: exp_b = 8'h10;
          default: begin
            if (pkt_pid == P_NULL) begin exp_b = 8'hFF; rq = "R5"; end
            else exp_b = 8'hC3 ^ pkt_pid[7:0];
          end
        endcase
        chk(out_data == exp_b, rq, "packet byte", out_data, exp_b);
        chk(pay_take == (mon_idx >= 4 && pkt_pid != P_NULL), "R7", "pay_take",
            pay_take, (mon_idx >= 4 && pkt_pid != P_NULL));
        chk(out_last == (mon_idx == 187), "R8", "out_last", out_last, mon_idx == 187);
        if (mon_idx == 187) begin mon_idx = 0; last_pend = 1; end
        else mon_idx++;
      end else if (out_valid && !out_ready) begin
        stall_pend = 1;
        stall_data = out_data;
        n_stall++;
      end
    end
  end

  task automatic wait_until(input int c);
    while (cyc < c) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    prog_rdy = '0;
    out_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!pkt_busy && !out_valid && !pkt_trig && src_grant == '0, "R1",
        "outputs in reset", {pkt_busy, out_valid, pkt_trig}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!pkt_busy && !out_valid && !pkt_trig && src_grant == '0, "R1",
        "outputs after reset", {pkt_busy, out_valid, pkt_trig}, 0);
  endtask

  task automatic t_idle();
    int c_pat = 0, c_pmt = 0, c_sit = 0, c_pcr = 0, c_null = 0;
    int prev_null = -1;
    bit exact = 0;
    wait_until(20000);
    for (int i = 0; i < n_log; i++) begin
      if (log_pid[i] == P_PAT) begin
        c_pat++;
        if (i + 3 < n_log) begin
          chk(log_pid[i+1] == P_PMT, "R3", "map table after association", log_pid[i+1], P_PMT);
          chk(log_pid[i+2] == P_SIT, "R3", "selection table third", log_pid[i+2], P_SIT);
          chk(log_pid[i+3] == P_PCR, "R3", "clock reference last", log_pid[i+3], P_PCR);
        end
      end
      if (log_pid[i] == P_PMT) c_pmt++;
      if (log_pid[i] == P_SIT) c_sit++;
      if (log_pid[i] == P_PCR) c_pcr++;
      if (log_pid[i] == P_NULL) begin
        c_null++;
        if (prev_null >= 0) begin
          chk(log_cyc[i] - log_cyc[prev_null] >= GAP * SLOT, "R6", "null spacing",
              log_cyc[i] - log_cyc[prev_null], GAP * SLOT);
          if (log_cyc[i] - log_cyc[prev_null] == GAP * SLOT) exact = 1;
        end
        prev_null = i;
      end
    end
    chk(c_pat == 6, "R4", "association table count", c_pat, 6);
    chk(c_pmt == 6, "R4", "map table count", c_pmt, 6);
    chk(c_sit == 6, "R4", "selection table count", c_sit, 6);
    chk(c_pcr == 6, "R4", "clock reference count", c_pcr, 6);
    chk(c_null > 0, "R5", "null packets sent when idle", c_null, 1);
    chk(exact, "R6", "null at minimum spacing", exact, 1);
    chk(n_log < 20000 / SLOT, "R6", "empty slots exist", n_log, 20000 / SLOT);
  endtask

  task automatic t_prog();
    int n0, n1, n2, first;
    wait_until(20100);
    prog_rdy = 2'b11; n0 = n_log;
    wait_until(26500);
    prog_rdy = 2'b10; n1 = n_log;
    wait_until(28000);
    prog_rdy = 2'b00; n2 = n_log;
    wait_until(29500);
    chk(n1 - n0 >= 20, "R2", "program 0 packet count", n1 - n0, 20);
    for (int i = n0 + 1; i < n1; i++)
      chk(log_pid[i] == P_BASE, "R2", "program 0 over tables and program 1",
          log_pid[i], P_BASE);
    chk(n2 - n1 >= 3, "R2", "program 1 packet count", n2 - n1, 3);
    for (int i = n1 + 1; i < n2; i++)
      chk(log_pid[i] == P_BASE + 1, "R2", "program 1 alone", log_pid[i], P_BASE + 1);
    first = n2;
    while (first < n_log && (log_pid[first] == P_BASE || log_pid[first] == P_BASE + 1))
      first++;
    chk(first <= n2 + 1, "R10", "pending tables served after programs", first - n2, 1);
    chk(log_pid[first] == P_PAT, "R10", "pending association table first", log_pid[first], P_PAT);
    chk(log_pid[first+1] == P_PMT, "R3", "pending map table second", log_pid[first+1], P_PMT);
    chk(log_pid[first+2] == P_SIT, "R3", "pending selection table third", log_pid[first+2], P_SIT);
    chk(log_pid[first+3] == P_PCR, "R3", "pending clock reference fourth", log_pid[first+3], P_PCR);
  endtask

  task automatic t_bp();
    int n0;
    wait_until(30500);
    n0 = n_log;
    for (int c = 0; c < 3000; c++) begin
      @(posedge clk); #1 out_ready = (c % 3) != 0;
    end
    out_ready = 1'b1;
    wait_until(34500);
    chk(n_stall > 0, "R9", "stalls seen", n_stall, 1);
    chk(n_log - n0 >= 5, "R10", "packets continue under back-pressure", n_log - n0, 5);
  endtask

  task automatic t_slots();
    for (int i = 1; i < n_log; i++)
      chk((log_cyc[i] - log_cyc[0]) % SLOT == 0, "R11", "start on slot boundary",
          (log_cyc[i] - log_cyc[0]) % SLOT, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    total++;
    bad++;
    $display("FAIL R8 watchdog expired: actual=%0d expected=%0d", cyc, 34500);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_prog();
    t_bp();
    t_slots();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule